// File: doc/BRIEF.md
# Effective Address Generator

This block turns the addressing-mode selector and operand bytes of an 8-bit processor instruction into the final 16-bit operand address. A request carries the mode code, the one or two bytes that follow the opcode, the X and Y index values and the address of the next instruction. Modes that need only arithmetic finish at once. The indirect modes first read a two-byte little-endian pointer through a byte-wide read port and then finish.

The request side uses a valid/ready handshake. The requester holds `req_valid` and all request fields steady until it sees `req_ready` high at a rising edge. The block keeps `req_ready` low while a pointer fetch is in flight, and that is its only form of back-pressure. The result side has no back-pressure: `done` is a one-cycle pulse, and `ea`, `is_imm` and `is_acc` stay valid from that pulse until the next result. The read port has a fixed latency of one cycle. Data for an address strobed in one cycle must be present on `rd_data` in the next cycle.

Top module: `eag_top`

## Requirements
- R1: `req_ready` is high whenever no pointer fetch is in flight and low for the three cycles after an indirect request is accepted. A request is taken only at an edge where `req_valid` and `req_ready` are both high, and a `req_valid` held high while `req_ready` is low produces no result.
- R2: Each accepted request produces exactly one single-cycle `done` pulse. For a non-indirect mode, the pulse comes in the cycle right after the accepting edge.
- R3: Mode 2 (page zero) gives `{8'h00, op_lo}`. Modes 3 and 4 add X or Y to `op_lo` modulo 256, so the result stays in 0x0000–0x00FF.
- R4: Mode 6 (absolute) gives `{op_hi, op_lo}`. Modes 7 and 8 add the zero-extended X or Y to it, wrapping at 0xFFFF.
- R5: Mode 5 (relative) gives `pc + sign_extend(op_lo)` modulo 65536.
- R6: Mode 1 (immediate) raises `is_imm`, and mode 0 (accumulator) raises `is_acc`, each with `ea` = 0. No other mode raises either flag, and the two are never high together.
- R7: For an indirect mode, `rd_en` is high in exactly the first and second cycles after acceptance. The first cycle reads the pointer's low byte and the second reads its high byte, and `done` comes in the fourth cycle after acceptance.
- R8: Mode 9 (indirect) reads the pointer low byte at `{op_hi, op_lo}` and the high byte at that address plus one, with 16-bit wrap. `ea` is that pointer.
- R9: Mode 10 (pre-indexed indirect) reads the low byte at `{8'h00, op_lo + X}` and the high byte at the next page-zero address, wrapping within page zero. `ea` is that pointer.
- R10: Mode 11 (post-indexed indirect) reads the low byte at `{8'h00, op_lo}` and the high byte at the next page-zero address, wrapping within page zero. `ea` is the pointer plus zero-extended Y, with 16-bit wrap.
- R11: `rd_en` is low and `rd_addr` is 0 in every cycle in which no pointer byte is being read.
- R12: Mode codes 12 to 15 complete like direct modes, with `ea` = 0 and both flags low.
- R13: During and right after reset, `req_ready` is high and `done`, `rd_en`, `ea`, `is_imm` and `is_acc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mode | input | 4 | Addressing-mode code |
| req_op_lo | input | 8 | First operand byte |
| req_op_hi | input | 8 | Second operand byte |
| req_idx_x | input | 8 | X index value |
| req_idx_y | input | 8 | Y index value |
| req_pc | input | 16 | Address of the next instruction |
| rd_en | output | 1 | Pointer byte read strobe |
| rd_addr | output | 16 | Pointer byte address |
| rd_data | input | 8 | Read data, one cycle after the strobe |
| done | output | 1 | Result pulse |
| ea | output | 16 | Effective address |
| is_imm | output | 1 | Operand is the immediate byte |
| is_acc | output | 1 | Operand is the accumulator |

## Verification
A non-indirect result is due one edge after the accepting edge. An indirect request gives read strobes after edges one and two, a quiet cycle after edge three and the result after edge four. The bench drives each request just after a falling edge and then checks `done`, `rd_en`, `rd_addr` and `req_ready` at each following falling edge against those exact cycle positions, including the cycle after `done` to confirm the pulse is single. The bench's memory model answers one cycle after the strobe, and each byte it returns is computed from the address, so the expected pointer is known without storing a memory image.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_ACC = 4'd0;
  localparam logic [MODE_W-1:0] MD_IMM = 4'd1;
  localparam logic [MODE_W-1:0] MD_ZP  = 4'd2;
  localparam logic [MODE_W-1:0] MD_ZPX = 4'd3;
  localparam logic [MODE_W-1:0] MD_ZPY = 4'd4;
  localparam logic [MODE_W-1:0] MD_REL = 4'd5;
  localparam logic [MODE_W-1:0] MD_ABS = 4'd6;
  localparam logic [MODE_W-1:0] MD_ABX = 4'd7;
  localparam logic [MODE_W-1:0] MD_ABY = 4'd8;
  localparam logic [MODE_W-1:0] MD_IND = 4'd9;
  localparam logic [MODE_W-1:0] MD_XIN = 4'd10;
  localparam logic [MODE_W-1:0] MD_INY = 4'd11;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2,
    FS_WAIT = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/eag_direct.sv
module eag_direct
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [MODE_W-1:0]   mode,
  input  logic [BYTE_W-1:0]   op_lo,
  input  logic [BYTE_W-1:0]   op_hi,
  input  logic [BYTE_W-1:0]   idx_x,
  input  logic [BYTE_W-1:0]   idx_y,
  input  logic [2*BYTE_W-1:0] pc,
  output logic [2*BYTE_W-1:0] ea,
  output logic                is_imm,
  output logic                is_acc,
  output logic                needs_ptr,
  output logic [2*BYTE_W-1:0] ptr_addr,
  output logic                ptr_zp,
  output logic [BYTE_W-1:0]   post_add
);
  localparam int ADDR_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ZERO_B = '0;

  logic [ADDR_W-1:0] abs_a;
  logic [BYTE_W-1:0] zp_x;
  logic [BYTE_W-1:0] zp_y;
  logic [ADDR_W-1:0] rel_off;

  assign abs_a   = {op_hi, op_lo};
  assign zp_x    = op_lo + idx_x;
  assign zp_y    = op_lo + idx_y;
  assign rel_off = {{BYTE_W{op_lo[BYTE_W-1]}}, op_lo};

  always_comb begin
    ea        = '0;
    is_imm    = 1'b0;
    is_acc    = 1'b0;
    needs_ptr = 1'b0;
    ptr_addr  = '0;
    ptr_zp    = 1'b0;
    post_add  = '0;
    case (mode)
      MD_ACC: is_acc = 1'b1;
      MD_IMM: is_imm = 1'b1;
      MD_ZP:  ea = {ZERO_B, op_lo};
      MD_ZPX: ea = {ZERO_B, zp_x};
      MD_ZPY: ea = {ZERO_B, zp_y};
      MD_REL: ea = pc + rel_off;
      MD_ABS: ea = abs_a;
      MD_ABX: ea = abs_a + {ZERO_B, idx_x};
      MD_ABY: ea = abs_a + {ZERO_B, idx_y};
      MD_IND: begin
        needs_ptr = 1'b1;
        ptr_addr  = abs_a;
      end
      MD_XIN: begin
        needs_ptr = 1'b1;
        ptr_addr  = {ZERO_B, zp_x};
        ptr_zp    = 1'b1;
      end
      MD_INY: begin
        needs_ptr = 1'b1;
        ptr_addr  = {ZERO_B, op_lo};
        ptr_zp    = 1'b1;
        post_add  = idx_y;
      end
      default: ea = '0;
    endcase
  end
endmodule

// File: rtl/eag_ptr_fetch.sv
module eag_ptr_fetch
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2*BYTE_W-1:0] ptr_addr,
  input  logic                ptr_zp,
  input  logic [BYTE_W-1:0]   post_add,
  output logic                busy,
  output logic                rd_en,
  output logic [2*BYTE_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic                fin,
  output logic [2*BYTE_W-1:0] fin_ea
);
  localparam int ADDR_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ZERO_B = '0;

  fetch_state_e      st_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              zp_q;
  logic [BYTE_W-1:0] add_q;
  logic [BYTE_W-1:0] lo_q;
  logic [ADDR_W-1:0] hi_addr;
  logic [BYTE_W-1:0] zp_next;

  assign zp_next = ptr_q[BYTE_W-1:0] + 1'b1;
  assign hi_addr = zp_q ? {ZERO_B, zp_next} : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      ptr_q <= '0;
      zp_q  <= 1'b0;
      add_q <= '0;
      lo_q  <= '0;
    end else begin
      case (st_q)
        FS_IDLE: if (start) begin
          ptr_q <= ptr_addr;
          zp_q  <= ptr_zp;
          add_q <= post_add;
          st_q  <= FS_LO;
        end
        FS_LO:   st_q <= FS_HI;
        FS_HI: begin
          lo_q <= rd_data;
          st_q <= FS_WAIT;
        end
        FS_WAIT: st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    case (st_q)
      FS_LO: begin
        rd_en   = 1'b1;
        rd_addr = ptr_q;
      end
      FS_HI: begin
        rd_en   = 1'b1;
        rd_addr = hi_addr;
      end
      default: ;
    endcase
  end

  assign busy   = (st_q != FS_IDLE);
  assign fin    = (st_q == FS_WAIT);
  assign fin_ea = {rd_data, lo_q} + {ZERO_B, add_q};
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          req_mode,
  input  logic [BYTE_W-1:0]   req_op_lo,
  input  logic [BYTE_W-1:0]   req_op_hi,
  input  logic [BYTE_W-1:0]   req_idx_x,
  input  logic [BYTE_W-1:0]   req_idx_y,
  input  logic [2*BYTE_W-1:0] req_pc,
  output logic                rd_en,
  output logic [2*BYTE_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic                done,
  output logic [2*BYTE_W-1:0] ea,
  output logic                is_imm,
  output logic                is_acc
);
  localparam int ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] dir_ea;
  logic              dir_imm;
  logic              dir_acc;
  logic              dir_ptr;
  logic [ADDR_W-1:0] dir_ptr_addr;
  logic              dir_ptr_zp;
  logic [BYTE_W-1:0] dir_post;
  logic              fetch_busy;
  logic              fetch_fin;
  logic [ADDR_W-1:0] fetch_ea;
  logic              accept;

  logic              done_q;
  logic [ADDR_W-1:0] ea_q;
  logic              imm_q;
  logic              acc_q;

  eag_direct #(.BYTE_W(BYTE_W)) direct_i (
    .mode      (req_mode),
    .op_lo     (req_op_lo),
    .op_hi     (req_op_hi),
    .idx_x     (req_idx_x),
    .idx_y     (req_idx_y),
    .pc        (req_pc),
    .ea        (dir_ea),
    .is_imm    (dir_imm),
    .is_acc    (dir_acc),
    .needs_ptr (dir_ptr),
    .ptr_addr  (dir_ptr_addr),
    .ptr_zp    (dir_ptr_zp),
    .post_add  (dir_post)
  );

  assign req_ready = !fetch_busy;
  assign accept    = req_valid && req_ready;

  eag_ptr_fetch #(.BYTE_W(BYTE_W)) fetch_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept && dir_ptr),
    .ptr_addr (dir_ptr_addr),
    .ptr_zp   (dir_ptr_zp),
    .post_add (dir_post),
    .busy     (fetch_busy),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .fin      (fetch_fin),
    .fin_ea   (fetch_ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ea_q   <= '0;
      imm_q  <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fetch_fin) begin
        done_q <= 1'b1;
        ea_q   <= fetch_ea;
        imm_q  <= 1'b0;
        acc_q  <= 1'b0;
      end else if (accept && !dir_ptr) begin
        done_q <= 1'b1;
        ea_q   <= dir_ea;
        imm_q  <= dir_imm;
        acc_q  <= dir_acc;
      end
    end
  end

  assign done   = done_q;
  assign ea     = ea_q;
  assign is_imm = imm_q;
  assign is_acc = acc_q;
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rd_en,
  input logic [2*BYTE_W-1:0] rd_addr,
  input logic                done,
  input logic                is_imm,
  input logic                is_acc
);
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_en) else $error("idle read"); // R11

  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |=> !rd_en) else $error("read burst too long"); // R7

  AST_HI_NEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr[BYTE_W-1:0] == $past(rd_addr[BYTE_W-1:0]) + 1'b1))
    else $error("high byte address"); // R8

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_imm && is_acc)) else $error("both flags"); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(req_valid && req_ready)) |=> !done) else $error("done repeated"); // R2

  AST_DONE_QUIET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en) else $error("read during done"); // R11
endmodule

bind eag_top eag_checker #(.BYTE_W(BYTE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .done      (done),
  .is_imm    (is_imm),
  .is_acc    (is_acc)
);

// File: tb/eag_top_tb_top.sv
module eag_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_op_lo = '0;
  logic [7:0]  req_op_hi = '0;
  logic [7:0]  req_idx_x = '0;
  logic [7:0]  req_idx_y = '0;
  logic [15:0] req_pc = '0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        done;
  logic [15:0] ea;
  logic        is_imm;
  logic        is_acc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  eag_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_op_lo(req_op_lo), .req_op_hi(req_op_hi),
    .req_idx_x(req_idx_x), .req_idx_y(req_idx_y), .req_pc(req_pc),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .ea(ea), .is_imm(is_imm), .is_acc(is_acc)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mem_byte(rd_addr);

  function automatic bit is_ind(input logic [3:0] m);
    return (m == 4'd9) || (m == 4'd10) || (m == 4'd11);
  endfunction

  function automatic logic [15:0] ptr_lo_addr(input logic [3:0] m, input logic [7:0] lo,
                                              input logic [7:0] hi, input logic [7:0] x);
    if (m == 4'd9) return {hi, lo};
    if (m == 4'd10) return {8'h00, 8'(lo + x)};
    return {8'h00, lo};
  endfunction

  function automatic logic [15:0] ptr_hi_addr(input logic [3:0] m, input logic [15:0] p);
    if (m == 4'd9) return p + 16'd1;
    return {8'h00, 8'(p[7:0] + 8'd1)};
  endfunction

  function automatic logic [15:0] exp_ea(input logic [3:0] m, input logic [7:0] lo,
                                         input logic [7:0] hi, input logic [7:0] x,
                                         input logic [7:0] y, input logic [15:0] pc);
    logic [15:0] p0;
    logic [15:0] ptr;
    p0  = ptr_lo_addr(m, lo, hi, x);
    ptr = {mem_byte(ptr_hi_addr(m, p0)), mem_byte(p0)};
    case (m)
      4'd2:  return {8'h00, lo};
      4'd3:  return {8'h00, 8'(lo + x)};
      4'd4:  return {8'h00, 8'(lo + y)};
      4'd5:  return pc + {{8{lo[7]}}, lo};
      4'd6:  return {hi, lo};
      4'd7:  return {hi, lo} + {8'h00, x};
      4'd8:  return {hi, lo} + {8'h00, y};
      4'd9:  return ptr;
      4'd10: return ptr;
      4'd11: return ptr + {8'h00, y};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string req_tag(input logic [3:0] m);
    case (m)
      4'd0, 4'd1: return "R6";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R5";
      4'd6, 4'd7, 4'd8: return "R4";
      4'd9: return "R8";
      4'd10: return "R9";
      4'd11: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc);
    logic [15:0] p0;
    logic [15:0] e;
    string t;
    t  = req_tag(m);
    e  = exp_ea(m, lo, hi, x, y, pc);
    p0 = ptr_lo_addr(m, lo, hi, x);
    @(negedge clk);
    req_mode = m; req_op_lo = lo; req_op_hi = hi;
    req_idx_x = x; req_idx_y = y; req_pc = pc; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1 ready before request", 32'(req_ready), 1);
    @(negedge clk);
    if (is_ind(m)) begin
      // R1: hold a second request while busy; it must be ignored
      req_mode = 4'd2; req_op_lo = 8'h77;
      chk(rd_en == 1'b1 && rd_addr == p0, {t, " R7 low pointer read"}, 32'({rd_en, rd_addr}), 32'({1'b1, p0}));
      chk(req_ready == 1'b0 && done == 1'b0, "R1 busy after accept", 32'({req_ready, done}), 0);
      @(negedge clk);
      chk(rd_en == 1'b1 && rd_addr == ptr_hi_addr(m, p0), {t, " R7 high pointer read"},
          32'({rd_en, rd_addr}), 32'({1'b1, ptr_hi_addr(m, p0)}));
      @(negedge clk);
      req_valid = 1'b0;
      chk(rd_en == 1'b0 && rd_addr == 16'h0 && done == 1'b0, "R11 quiet wait cycle",
          32'({rd_en, rd_addr, done}), 0);
      chk(req_ready == 1'b0, "R1 busy in wait cycle", 32'(req_ready), 0);
      @(negedge clk);
    end else begin
      req_valid = 1'b0;
    end
    chk(done == 1'b1, {t, " R2 done due"}, 32'(done), 1);
    chk(ea == e, {t, " address"}, 32'(ea), 32'(e));
    chk(is_imm == (m == 4'd1) && is_acc == (m == 4'd0), "R6 operand flags",
        32'({is_imm, is_acc}), 32'({m == 4'd1, m == 4'd0}));
    chk(rd_en == 1'b0 && rd_addr == 16'h0, "R11 port idle at done", 32'({rd_en, rd_addr}), 0);
    chk(req_ready == 1'b1, "R1 ready at done", 32'(req_ready), 1);
    @(negedge clk);
    chk(done == 1'b0, "R2 single done pulse", 32'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(req_ready == 1'b1 && done == 1'b0 && rd_en == 1'b0, "R13 reset outputs",
        32'({req_ready, done, rd_en}), 32'(3'b100));
    chk(ea == 16'h0 && is_imm == 1'b0 && is_acc == 1'b0, "R13 reset result",
        32'({ea, is_imm, is_acc}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R13 after reset", 32'({req_ready, done}), 32'(2'b10));

    run_req(4'd0, 8'h12, 8'h34, 8'h01, 8'h02, 16'h1000); // R6 accumulator
    run_req(4'd1, 8'h12, 8'h34, 8'h01, 8'h02, 16'h1000); // R6 immediate
    run_req(4'd2, 8'hFE, 8'h99, 8'h00, 8'h00, 16'h0000); // R3
    run_req(4'd3, 8'hF0, 8'h55, 8'h20, 8'h00, 16'h0000); // R3 wrap in page 0
    run_req(4'd4, 8'hFF, 8'h55, 8'h00, 8'h01, 16'h0000); // R3 wrap
    run_req(4'd5, 8'h80, 8'h00, 8'h00, 8'h00, 16'h0040); // R5 negative
    run_req(4'd5, 8'h7F, 8'h00, 8'h00, 8'h00, 16'hFFF0); // R5 wrap
    run_req(4'd6, 8'h34, 8'h12, 8'h00, 8'h00, 16'h0000); // R4 little-endian
    run_req(4'd7, 8'hF0, 8'hFF, 8'h20, 8'h00, 16'h0000); // R4 wrap
    run_req(4'd8, 8'hFF, 8'h12, 8'h00, 8'h01, 16'h0000); // R4 carry to high
    run_req(4'd9, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0000); // R8 pointer at top
    run_req(4'd9, 8'hFF, 8'h02, 8'h00, 8'h00, 16'h0000); // R8 crosses page
    run_req(4'd10, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0000); // R9 pointer at 0xFF
    run_req(4'd10, 8'h80, 8'h33, 8'h90, 8'h00, 16'h0000); // R9 index wrap
    run_req(4'd11, 8'hFF, 8'h00, 8'h00, 8'hFF, 16'h0000); // R10 page-0 wrap
    run_req(4'd11, 8'h10, 8'h00, 8'h00, 8'h80, 16'h0000); // R10
    run_req(4'd12, 8'h12, 8'h34, 8'h01, 8'h02, 16'h1000); // R12
    run_req(4'd15, 8'hAA, 8'hBB, 8'h01, 8'h02, 16'h1000); // R12

    for (int i = 0; i < 400; i++) begin
      run_req(4'($urandom % 16), 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 16'($urandom));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule